// File: doc/BRIEF.md
# Banked Slice Memory with Parallel Write Fan-Out and Read Summation

This block is a small on-chip store holding a three-dimensional array of 32-bit integers, four entries along each axis, with element `[i][j][k]` at element address `i*16 + j*4 + k`. The store is split into four parallel banks. Element-address bits 5:4 (the outer index `i`) choose the bank. Each bank word is 128 bits wide and holds the four `k` entries of one `(i, j)` row. Every bank has one write port and one read port of its own, so all banks are reached in the same cycle and no two accesses ever wait on each other.

A write command takes a 2-bit slice index and a data word. It stores that word into all sixteen elements whose middle index equals the slice index, writing one row in every bank at once. A read command takes a slice index and returns the 32-bit sum, wrapping modulo 2^32, of the sixteen elements of that slice. The sum comes from an adder reduction over the four bank read words. It is ready one clock after the request, and a valid strobe marks it.

Reset clears the whole array to zero. The block also drives a constant output with the lowest byte-address bank-select bit. Because each element is four bytes, element bank bits 5:4 sit at byte-address bits 7:6.

Top module: `bsm_banked_mem`

## Requirements
- R1: While reset is held, and after it is released with no command given, `rd_valid` is 0 and `rdata` is 0. A read of any slice before any write returns 0.
- R2: `rd_valid` is 1 in exactly the cycle after a cycle with `rd_en` = 1, and 0 after a cycle with `rd_en` = 0.
- R3: A write with slice index `w` and data `d` sets all sixteen elements `[i][w][k]`, so a later read of slice `w` returns `16*d` modulo 2^32.
- R4: A write to slice `w` leaves the elements of every other slice unchanged.
- R5: A read sum wraps modulo 2^32. For example, slice data 0x10000000 reads back as 0, and 0xFFFFFFFF reads back as 0xFFFFFFF0.
- R6: When a read and a write name the same slice in one cycle, the read returns the sum of the data held before that write, and the write still takes effect for later reads.
- R7: When a read and a write name different slices in one cycle, both commands take full effect.
- R8: `rdata` keeps the last read result through cycles with no read request, even across writes.
- R9: `byte_bank_lsb` equals 6: the element bank LSB (4) plus log2 of the element size in bytes (4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears array and outputs |
| wr_en | input | 1 | Write command strobe |
| waddr | input | 2 | Slice (middle) index for the write |
| wdata | input | 32 | Value stored into every element of the slice |
| rd_en | input | 1 | Read command strobe |
| raddr | input | 2 | Slice (middle) index for the read |
| rd_valid | output | 1 | High the cycle after a read request |
| rdata | output | 32 | Wrapped sum of the sixteen elements of the read slice |
| byte_bank_lsb | output | 8 | Lowest byte-address bit used for bank selection (6) |

## Verification
Every element of a slice feeds the sum, so a single corrupted element, a bank that misses a write, or a row decode that hits the wrong slice changes `rdata` on the first read of the affected slice. That wrong value appears one cycle after the request. A write leaking into a neighbouring slice shows up only when that neighbour is read, so the directed tests read every slice after each write pattern. A write-before-read ordering error appears only when both strobes name the same slice, and it shows as the new sum one cycle too early.

// File: rtl/bsm_pkg.sv
package bsm_pkg;

  // Element address of a[i][j][k] for a cube of side 2**idx_w.
  function automatic int unsigned elem_addr(input int unsigned i, input int unsigned j,
                                            input int unsigned k, input int unsigned idx_w);
    return (i << (2 * idx_w)) | (j << idx_w) | k;
  endfunction

  // Bank index taken from chosen address bits.
  function automatic int unsigned bank_of(input int unsigned addr, input int unsigned lsb,
                                          input int unsigned nbits);
    return (addr >> lsb) & ((32'd1 << nbits) - 1);
  endfunction

  // Byte-address position of an element-address bit.
  function automatic int unsigned byte_bit(input int unsigned elem_bit,
                                           input int unsigned elem_bytes);
    return elem_bit + $clog2(elem_bytes);
  endfunction

endpackage

// File: rtl/bsm_addr_decode.sv
module bsm_addr_decode #(
  parameter int IDX_W     = 2,
  parameter int BANK_LSB  = 4,
  parameter int NUM_BANKS = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  input  logic [IDX_W-1:0]          idx,
  output logic [NUM_BANKS-1:0]      bank_en,
  output logic [(1<<IDX_W)-1:0]     row_sel
);
  import bsm_pkg::*;
  localparam int ROWS = 1 << IDX_W;

  // Row select inside every bank is the middle index, one-hot.
  always_comb begin
    row_sel = '0;
    if (en) row_sel[idx] = 1'b1;
  end

  // For each bank, the element a[b][idx][0] is decoded through the
  // bank-select bits; the bank is enabled when the decode names it.
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    int unsigned ea;
    always_comb begin
      ea         = elem_addr(b, int'(idx), 0, IDX_W);
      bank_en[b] = en && (bank_of(ea, BANK_LSB, IDX_W) == b);
    end
  end

  // R3: a command selects exactly one row and reaches every bank
  assert_row_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> ($onehot(row_sel) && (bank_en == {NUM_BANKS{1'b1}})));
  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (row_sel == '0 && bank_en == '0));

endmodule

// File: rtl/bsm_bank.sv
module bsm_bank #(
  parameter int ROWS  = 4,
  parameter int ROW_W = 128
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [$clog2(ROWS)-1:0] wrow,
  input  logic [ROW_W-1:0]        wword,
  input  logic                    re,
  input  logic [$clog2(ROWS)-1:0] rrow,
  output logic [ROW_W-1:0]        rword
);
  logic [ROW_W-1:0] mem [ROWS];

  // Write port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) mem[r] <= '0;
    end else if (we) begin
      mem[wrow] <= wword;
    end
  end

  // Independent read port, registered; samples the array before the
  // same-edge write lands (read-before-write).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rword <= '0;
    else if (re) rword <= mem[rrow];
  end

  assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem[$past(wrow)] == $past(wword)));
  assert_read_old_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (re && we && rrow == wrow) |=> (rword == $past(mem[rrow])));
  assert_read_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !re |=> $stable(rword));

endmodule

// File: rtl/bsm_reduce.sv
module bsm_reduce #(
  parameter int LANES  = 16,
  parameter int DATA_W = 32
) (
  input  logic [LANES*DATA_W-1:0] lanes,
  output logic [DATA_W-1:0]       total
);
  // Wrapping sum of all lanes; width truncation gives modulo 2**DATA_W.
  function automatic logic [DATA_W-1:0] add_lanes(input logic [LANES*DATA_W-1:0] v);
    logic [DATA_W-1:0] acc;
    acc = '0;
    for (int n = 0; n < LANES; n++) acc = acc + v[n*DATA_W +: DATA_W];
    return acc;
  endfunction

  assign total = add_lanes(lanes);

endmodule

// File: rtl/bsm_banked_mem.sv
module bsm_banked_mem #(
  parameter int DATA_W     = 32,
  parameter int DIM        = 4,
  parameter int ELEM_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [$clog2(DIM)-1:0]  waddr,
  input  logic [DATA_W-1:0]       wdata,
  input  logic                    rd_en,
  input  logic [$clog2(DIM)-1:0]  raddr,
  output logic                    rd_valid,
  output logic [DATA_W-1:0]       rdata,
  output logic [7:0]              byte_bank_lsb
);
  import bsm_pkg::*;

  localparam int IDX_W     = $clog2(DIM);
  localparam int BANK_LSB  = 2 * IDX_W;          // element bits of outer index
  localparam int NUM_BANKS = 1 << IDX_W;         // 2 ** bank-select bits
  localparam int ROW_W     = DIM * DATA_W;       // one (i, j) row per word
  localparam int LANES     = NUM_BANKS * DIM;
  localparam int BYTE_LSB  = byte_bit(BANK_LSB, ELEM_BYTES);

  logic [NUM_BANKS-1:0]    wbank_en, rbank_en;
  logic [DIM-1:0]          wrow_sel, rrow_sel;
  logic [ROW_W-1:0]        fill_word;
  logic [LANES*DATA_W-1:0] read_lanes;
  logic [DATA_W-1:0]       slice_sum;

  assign fill_word     = {DIM{wdata}};
  assign byte_bank_lsb = 8'(BYTE_LSB);

  bsm_addr_decode #(.IDX_W(IDX_W), .BANK_LSB(BANK_LSB), .NUM_BANKS(NUM_BANKS)) u_wdec (
    .clk(clk), .rst_n(rst_n), .en(wr_en), .idx(waddr),
    .bank_en(wbank_en), .row_sel(wrow_sel));

  bsm_addr_decode #(.IDX_W(IDX_W), .BANK_LSB(BANK_LSB), .NUM_BANKS(NUM_BANKS)) u_rdec (
    .clk(clk), .rst_n(rst_n), .en(rd_en), .idx(raddr),
    .bank_en(rbank_en), .row_sel(rrow_sel));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bsm_bank #(.ROWS(DIM), .ROW_W(ROW_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .we(wbank_en[b]), .wrow(waddr), .wword(fill_word),
      .re(rbank_en[b]), .rrow(raddr),
      .rword(read_lanes[b*ROW_W +: ROW_W]));
  end

  bsm_reduce #(.LANES(LANES), .DATA_W(DATA_W)) u_sum (
    .lanes(read_lanes), .total(slice_sum));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= rd_en;
  end

  assign rdata = slice_sum;

  // R2: valid strobe timing
  assert_valid_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  assert_no_valid_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
  // R8: result holds while no read is issued
  assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
  // R1: outputs quiet during reset
  always_comb begin
    if (!rst_n) assert_reset_quiet_R1: assert (rd_valid == 1'b0);
  end
  // R9: unused-ports-free bank bit report
  always_comb begin
    assert_byte_lsb_R9: assert (byte_bank_lsb == 8'(BANK_LSB + $clog2(ELEM_BYTES)));
  end

endmodule

// File: tb/bsm_banked_mem_test.sv
module bsm_banked_mem_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  waddr = '0, raddr = '0;
  logic [31:0] wdata = '0;
  logic        rd_valid;
  logic [31:0] rdata;
  logic [7:0]  byte_bank_lsb;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] model [4];     // every element of a slice holds the same value
  logic [31:0] last_sum = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bsm_banked_mem uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .waddr(waddr), .wdata(wdata),
    .rd_en(rd_en), .raddr(raddr), .rd_valid(rd_valid), .rdata(rdata),
    .byte_bank_lsb(byte_bank_lsb));

  function automatic logic [31:0] slice_total(input logic [31:0] v);
    logic [31:0] s = '0;
    for (int i = 0; i < 4; i++)
      for (int k = 0; k < 4; k++) s = s + v;
    return s;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One command cycle; checks the read result one cycle after the request.
  task automatic cmd(input bit we, input logic [1:0] wa, input logic [31:0] wd,
                     input bit re, input logic [1:0] ra, input string req);
    logic [31:0] exp;
    @(negedge clk);
    wr_en = we; waddr = wa; wdata = wd; rd_en = re; raddr = ra;
    exp = slice_total(model[ra]);          // old data: read-before-write
    @(posedge clk); #1;
    wr_en = 0; rd_en = 0;
    if (we) model[wa] = wd;
    if (re) begin
      last_sum = exp;
      check({req, " R2 valid"}, {31'd0, rd_valid}, 32'd1);
      check(req, rdata, exp);
    end else begin
      check({req, " R2 idle"}, {31'd0, rd_valid}, 32'd0);
      check({req, " R8 hold"}, rdata, last_sum);
    end
  endtask

  task automatic t_reset;
    check("R1 valid in reset", {31'd0, rd_valid}, 32'd0);
    check("R1 rdata in reset", rdata, 32'd0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    check("R1 valid after reset", {31'd0, rd_valid}, 32'd0);
    for (int s = 0; s < 4; s++) cmd(0, 0, 0, 1, 2'(s), "R1 empty read");
  endtask

  task automatic t_fill_and_isolate;
    cmd(1, 2, 32'h0000_0003, 0, 0, "R3 write");
    for (int s = 0; s < 4; s++) cmd(0, 0, 0, 1, 2'(s), "R3/R4 slice read");
    cmd(1, 0, 32'h1234_5678, 0, 0, "R4 write");
    for (int s = 0; s < 4; s++) cmd(0, 0, 0, 1, 2'(s), "R4 slice read");
  endtask

  task automatic t_wrap;
    cmd(1, 1, 32'h1000_0000, 1, 1, "R5 rbw setup");
    cmd(0, 0, 0, 1, 1, "R5 wrap to zero");
    cmd(1, 3, 32'hFFFF_FFFF, 0, 0, "R5 write");
    cmd(0, 0, 0, 1, 3, "R5 wrap all ones");
  endtask

  task automatic t_same_cycle;
    cmd(1, 2, 32'h0000_0100, 1, 2, "R6 same slice old data");
    cmd(0, 0, 0, 1, 2, "R6 new data visible");
    cmd(1, 0, 32'h0000_0007, 1, 3, "R7 different slices read");
    cmd(0, 0, 0, 1, 0, "R7 write landed");
  endtask

  task automatic t_hold;
    cmd(0, 0, 0, 1, 2, "R8 read");
    cmd(1, 2, 32'hDEAD_BEEF, 0, 0, "R8 write no read");
    cmd(0, 0, 0, 0, 0, "R8 idle");
    cmd(0, 0, 0, 1, 2, "R8 reread");
  endtask

  task automatic t_byte_bits;
    check("R9 byte bank lsb", {24'd0, byte_bank_lsb}, 32'd6);
  endtask

  task automatic t_mixed;
    logic [31:0] lcg = 32'h1ACF_0001;
    for (int n = 0; n < 300; n++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      cmd(lcg[31], lcg[3:2], lcg, lcg[30], lcg[5:4], "R3/R6/R7 mixed");
    end
  endtask

  initial begin
    for (int s = 0; s < 4; s++) model[s] = '0;
    #(CLK_PERIOD * 2);
    t_reset();
    t_fill_and_isolate();
    t_wrap();
    t_same_cycle();
    t_hold();
    t_byte_bits();
    t_mixed();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule